// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This block is a single lane of a vector integer unit. It shifts one element by a signed count taken from a second operand. A count of zero or more shifts left, and a negative count shifts right by its magnitude. Right shifts can round half up. Left shifts can saturate, and when they do the result is clamped and a sticky saturation flag is set. Three value interpretations are supported: signed, unsigned, and signed input with an unsigned result. Each applies at element widths of 8, 16, 32 and 64 bits.

The element sits in the low bits of a 64-bit source operand. The count is the low byte of a 64-bit count operand, read as a two's-complement value. One operation is accepted on each clock edge at which `op_valid` is high. Its result and the updated flag appear at the outputs after that edge. The flag accumulates across operations and only reset clears it.

Top module: `vsat_shift`

## Requirements
- R1: `size_sel` picks the element width W: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. `mode_sel` picks the interpretation: 00 is signed, 01 and 11 are unsigned, and 10 is signed input with an unsigned result. Source bits at or above W and count-operand bits 8 to 63 have no effect. Result bits at or above W are always 0.
- R2: A count c of zero or more with c < W, and no saturation, gives the element shifted left by c, keeping its low W bits.
- R3: A count of −n with rounding off gives a truncating right shift by n. The shift is arithmetic in signed mode and logical in the other modes.
- R4: A count of −n with rounding on gives floor((x + 2^(n−1)) / 2^n), which is a right shift that rounds half up.
- R5: In signed mode, a count at or below −W gives 0 when rounding is on, and the sign fill (all ones or all zeros) when rounding is off.
- R6: In the unsigned modes, a count at or below −(W + r) gives 0, where r is 1 when rounding is on and 0 when it is off.
- R7: With `sat_en` high, a left shift by c < W saturates when the exact product x·2^c is outside the range of the element's interpretation.
- R8: A left shift by W or more gives 0 without saturating when the element is 0. Any other element saturates when `sat_en` is high, and gives 0 when `sat_en` is low.
- R9: Signed saturation gives 2^(W−1)−1 for a non-negative element and the pattern 2^(W−1) (most negative) for a negative one.
- R10: Unsigned saturation, in modes 01, 10 and 11, gives all ones over W bits.
- R11: In mode 10 with `sat_en` high, an element whose bit W−1 is set gives result 0 and saturates. Otherwise, mode 10 treats the element as unsigned.
- R12: `sat_sticky` is set by every saturating operation. It stays set through later operations and is never set when `sat_en` is low. Only reset clears it.
- R13: Reset drives `result` and `sat_sticky` to 0. Both update only on a clock edge with `op_valid` high and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Accept an operation on this edge |
| src_opnd | input | 64 | Element in the low W bits |
| amt_opnd | input | 64 | Signed shift count in bits 7:0 |
| size_sel | input | 2 | Element width select |
| mode_sel | input | 2 | Signed, unsigned or signed-to-unsigned |
| rnd_en | input | 1 | Round right shifts half up |
| sat_en | input | 1 | Enable saturation and flag update |
| result | output | 64 | Shifted element, zero above W |
| sat_sticky | output | 1 | Accumulated saturation flag |

## Verification
Clamp selection and flag accumulation happen in the same cycle. The bench therefore resets the flag before any operation that its arithmetic model predicts will saturate. That way each clamped value and each flag rise is judged on its own, and not hidden behind a flag that is already set. A directed sequence then follows a saturating operation with a clean one, to check that the flag stays set while the result changes. Rounding and the far-count range check also coincide at a count of exactly −W. There, the carry out of the last shifted bit must agree with the rule for that count, so the sweeps cover counts −W−1, −W and −W+1 at every width.

// File: rtl/vsat_shift_pkg.sv
package vsat_shift_pkg;
  localparam int ELEM_MAX_W = 64;
  localparam int CNT_W      = 8;
  localparam int SZ_W       = 2;

  typedef enum logic [1:0] {
    SHM_SIGNED  = 2'b00,
    SHM_UNSIGN  = 2'b01,
    SHM_SIG2UNS = 2'b10,
    SHM_UNSIGN2 = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/vsat_operand_prep.sv
module vsat_operand_prep #(
  parameter int DATA_W = vsat_shift_pkg::ELEM_MAX_W,
  parameter int SZ_W   = vsat_shift_pkg::SZ_W,
  parameter int WID_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0]  src,
  input  logic [SZ_W-1:0]    size_sel,
  output logic [DATA_W-1:0]  lane_mask,
  output logic [WID_W-1:0]   lane_w,
  output logic               lane_msb,
  output logic signed [DATA_W:0] x_sgn,
  output logic signed [DATA_W:0] x_uns
);
  localparam int NSIZES = 1 << SZ_W;

  logic [DATA_W-1:0] mask_tab [NSIZES];
  logic [WID_W-1:0]  wid_tab  [NSIZES];
  logic              msb_tab  [NSIZES];

  for (genvar g = 0; g < NSIZES; g++) begin : g_size
    localparam int EW = 8 << g;
    assign mask_tab[g] = {DATA_W{1'b1}} >> (DATA_W - EW);
    assign wid_tab[g]  = WID_W'(EW);
    assign msb_tab[g]  = src[EW-1];
  end

  always_comb begin
    lane_mask = mask_tab[size_sel];
    lane_w    = wid_tab[size_sel];
    lane_msb  = msb_tab[size_sel];
    x_uns     = {1'b0, src & lane_mask};
    x_sgn     = {lane_msb, (src & lane_mask) | ({DATA_W{lane_msb}} & ~lane_mask)};
  end
endmodule

// File: rtl/vsat_right_path.sv
module vsat_right_path #(
  parameter int DATA_W = vsat_shift_pkg::ELEM_MAX_W,
  parameter int CNT_W  = vsat_shift_pkg::CNT_W,
  parameter int WID_W  = $clog2(DATA_W) + 1
) (
  input  logic signed [DATA_W:0] x,
  input  logic [CNT_W-1:0]       n_mag,
  input  logic [WID_W-1:0]       lane_w,
  input  logic                   is_signed,
  input  logic                   rnd,
  output logic [DATA_W-1:0]      res_r
);
  logic [CNT_W:0]          lim;
  logic                    beyond;
  logic [WID_W-1:0]        amt;
  logic signed [DATA_W:0]  pre;
  logic signed [DATA_W:0]  trunc_v;
  logic [DATA_W:0]         rsum;

  always_comb begin
    lim     = (CNT_W+1)'(lane_w) + (CNT_W+1)'(rnd & ~is_signed);
    beyond  = {1'b0, n_mag} >= lim;
    amt     = n_mag[WID_W-1:0];
    pre     = x >>> (amt - WID_W'(1));
    trunc_v = x >>> amt;
    rsum    = (pre >>> 1) + {{DATA_W{1'b0}}, pre[0]};
    if (beyond)
      res_r = (is_signed & ~rnd) ? {DATA_W{x[DATA_W]}} : '0;
    else if (rnd)
      res_r = rsum[DATA_W-1:0];
    else
      res_r = trunc_v[DATA_W-1:0];
  end
endmodule

// File: rtl/vsat_left_path.sv
module vsat_left_path #(
  parameter int DATA_W = vsat_shift_pkg::ELEM_MAX_W,
  parameter int WID_W  = $clog2(DATA_W) + 1
) (
  input  logic signed [DATA_W:0] x,
  input  logic [WID_W-1:0]       s_amt,
  input  logic [WID_W-1:0]       lane_w,
  input  logic [DATA_W-1:0]      lane_mask,
  input  logic                   is_signed,
  output logic [DATA_W-1:0]      res_l,
  output logic                   ovf
);
  logic                   beyond;
  logic [DATA_W-1:0]      val;
  logic                   top;
  logic signed [DATA_W:0] rebuilt;
  logic signed [DATA_W:0] back;

  always_comb begin
    beyond  = s_amt >= lane_w;
    val     = (x[DATA_W-1:0] << s_amt[WID_W-2:0]) & lane_mask;
    top     = is_signed & (|(val & (lane_mask ^ (lane_mask >> 1))));
    rebuilt = {top, val | ({DATA_W{top}} & ~lane_mask)};
    back    = rebuilt >>> s_amt[WID_W-2:0];
    if (beyond) begin
      res_l = '0;
      ovf   = x != '0;
    end else begin
      res_l = val;
      ovf   = back != x;
    end
  end
endmodule

// File: rtl/vsat_shift.sv
module vsat_shift #(
  parameter int DATA_W = vsat_shift_pkg::ELEM_MAX_W,
  parameter int CNT_W  = vsat_shift_pkg::CNT_W,
  parameter int SZ_W   = vsat_shift_pkg::SZ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] src_opnd,
  input  logic [DATA_W-1:0] amt_opnd,
  input  logic [SZ_W-1:0]   size_sel,
  input  logic [1:0]        mode_sel,
  input  logic              rnd_en,
  input  logic              sat_en,
  output logic [DATA_W-1:0] result,
  output logic              sat_sticky
);
  import vsat_shift_pkg::*;
  localparam int WID_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0]      lane_mask;
  logic [WID_W-1:0]       lane_w;
  logic                   lane_msb;
  logic signed [DATA_W:0] x_sgn, x_uns, x_sel;
  logic [CNT_W-1:0]       cnt, n_mag;
  logic                   go_left, sgn_mode, su_neg, hit;
  logic [DATA_W-1:0]      res_r, res_l, clamp, res_d;
  logic                   ovf;
  logic                   sat_d;
  logic [DATA_W-CNT_W-1:0] unused_cnt_hi;

  assign unused_cnt_hi = amt_opnd[DATA_W-1:CNT_W];

  vsat_operand_prep #(.DATA_W(DATA_W), .SZ_W(SZ_W), .WID_W(WID_W)) u_prep (
    .src(src_opnd), .size_sel(size_sel), .lane_mask(lane_mask),
    .lane_w(lane_w), .lane_msb(lane_msb), .x_sgn(x_sgn), .x_uns(x_uns)
  );

  always_comb begin
    cnt      = amt_opnd[CNT_W-1:0];
    go_left  = ~cnt[CNT_W-1];
    n_mag    = ~cnt + CNT_W'(1);
    sgn_mode = shift_mode_e'(mode_sel) == SHM_SIGNED;
    su_neg   = (shift_mode_e'(mode_sel) == SHM_SIG2UNS) & sat_en & lane_msb;
    x_sel    = sgn_mode ? x_sgn : x_uns;
  end

  vsat_right_path #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WID_W(WID_W)) u_rpath (
    .x(x_sel), .n_mag(n_mag), .lane_w(lane_w), .is_signed(sgn_mode),
    .rnd(rnd_en), .res_r(res_r)
  );

  vsat_left_path #(.DATA_W(DATA_W), .WID_W(WID_W)) u_lpath (
    .x(x_sel), .s_amt(cnt[WID_W-1:0]), .lane_w(lane_w),
    .lane_mask(lane_mask), .is_signed(sgn_mode), .res_l(res_l), .ovf(ovf)
  );

  // Next-state logic
  always_comb begin
    if (sgn_mode)
      clamp = lane_msb ? (lane_mask ^ (lane_mask >> 1)) : (lane_mask >> 1);
    else
      clamp = lane_mask;
    hit   = 1'b0;
    res_d = '0;
    if (su_neg) begin
      hit = 1'b1;
    end else if (!go_left) begin
      res_d = res_r & lane_mask;
    end else if (ovf && sat_en) begin
      hit   = 1'b1;
      res_d = clamp;
    end else begin
      res_d = res_l;
    end
    sat_d = sat_sticky | hit;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      sat_sticky <= 1'b0;
    end else if (op_valid) begin
      result     <= res_d;
      sat_sticky <= sat_d;
    end
  end
endmodule

// File: rtl/vsat_shift_chk.sv
module vsat_shift_chk #(
  parameter int DATA_W = vsat_shift_pkg::ELEM_MAX_W,
  parameter int SZ_W   = vsat_shift_pkg::SZ_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [DATA_W-1:0] src_opnd,
  input logic [SZ_W-1:0]   size_sel,
  input logic [1:0]        mode_sel,
  input logic              sat_en,
  input logic [DATA_W-1:0] result,
  input logic              sat_sticky
);
  function automatic logic [DATA_W-1:0] mask_of(input logic [SZ_W-1:0] sz);
    return {DATA_W{1'b1}} >> (DATA_W - (8 << sz));
  endfunction

  logic [DATA_W-1:0] cur_mask;
  logic              cur_msb;
  assign cur_mask = mask_of(size_sel);
  assign cur_msb  = |(src_opnd & (cur_mask ^ (cur_mask >> 1)));

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (result & ~mask_of($past(size_sel))) == '0);

  assert_zero_elem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (src_opnd & cur_mask) == '0) |=> result == '0);

  assert_su_negative_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && mode_sel == 2'b10 && sat_en && cur_msb) |=> (result == '0 && sat_sticky));

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky |=> sat_sticky);

  assert_flag_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sat_en && !sat_sticky) |=> !sat_sticky);

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(result) && $stable(sat_sticky)));
endmodule

bind vsat_shift vsat_shift_chk #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_opnd(src_opnd),
  .size_sel(size_sel), .mode_sel(mode_sel), .sat_en(sat_en),
  .result(result), .sat_sticky(sat_sticky)
);

// File: tb/tb_vsat_shift.sv
module tb_vsat_shift;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [63:0] src_opnd = '0;
  logic [63:0] amt_opnd = '0;
  logic [1:0]  size_sel = '0;
  logic [1:0]  mode_sel = '0;
  logic        rnd_en = 1'b0;
  logic        sat_en = 1'b0;
  logic [63:0] result;
  logic        sat_sticky;

  int checks = 0;
  int errors = 0;
  logic exp_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsat_shift dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_opnd(src_opnd),
    .amt_opnd(amt_opnd), .size_sel(size_sel), .mode_sel(mode_sel),
    .rnd_en(rnd_en), .sat_en(sat_en), .result(result), .sat_sticky(sat_sticky)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (src=%h cnt=%0d sz=%0d md=%0d r=%b s=%b)",
               req, act, exp, src_opnd, $signed(amt_opnd[7:0]), size_sel, mode_sel, rnd_en, sat_en);
    end
  endtask

  // Arithmetic model: exact products and quotients in a wide signed integer
  function automatic logic [64:0] ref_op(input logic [63:0] s, input logic [63:0] a,
                                         input logic [1:0] sz, input logic [1:0] md,
                                         input logic r, input logic st, output string tag);
    int w, c, n;
    logic [63:0] m, e;
    logic signed [199:0] x, v, lo, hi, one;
    logic hit;
    w = 8 << sz;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    e = s & m;
    c = int'($signed(a[7:0]));
    one = 200'sd1;
    x = $signed({136'd0, e});
    if (md == 2'b00 && e[w-1]) x = x - (one <<< w);
    hit = 1'b0;
    if (md == 2'b10 && st && e[w-1]) begin
      tag = "R11";
      return {1'b1, 64'd0};
    end
    if (c < 0) begin
      n = -c;
      if (r) v = (x + (one <<< (n - 1))) >>> n;
      else   v = x >>> n;
      tag = r ? "R4" : "R3";
      if (md == 2'b00 && n >= w) tag = "R5";
      if (md != 2'b00 && n >= w + int'(r)) tag = "R6";
    end else begin
      v = x <<< c;
      if (md == 2'b00) begin
        lo = -(one <<< (w - 1));
        hi = (one <<< (w - 1)) - one;
      end else begin
        lo = '0;
        hi = (one <<< w) - one;
      end
      tag = (c >= w) ? "R8" : "R2";
      if ((v < lo || v > hi) && st) begin
        hit = 1'b1;
        if (md == 2'b00) v = (x < 0) ? lo : hi;
        else             v = hi;
        tag = $sformatf("%s+%s", (c >= w) ? "R8" : "R7", (md == 2'b00) ? "R9" : "R10");
      end
    end
    return {hit, v[63:0] & m};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_flag = 1'b0;
  endtask

  task automatic run_op(input logic [63:0] s, input logic [63:0] a, input logic [1:0] sz,
                        input logic [1:0] md, input logic r, input logic st, input bit auto_clr);
    logic [64:0] ex;
    logic [63:0] m;
    string tg;
    ex = ref_op(s, a, sz, md, r, st, tg);
    if (auto_clr && exp_flag) do_reset();
    m = ((8 << sz) == 64) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
    @(negedge clk);
    src_opnd = s; amt_opnd = a; size_sel = sz; mode_sel = md;
    rnd_en = r; sat_en = st; op_valid = 1'b1;
    @(posedge clk);
    #1;
    if (ex[64]) exp_flag = 1'b1;
    check(tg, result, ex[63:0]);
    check("R1", result & ~m, 64'd0);
    check("R12", {63'd0, sat_sticky}, {63'd0, exp_flag});
  endtask

  function automatic logic [63:0] pat(input int k, input int w);
    logic [63:0] m;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    case (k)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'd3;
      3: return m;
      4: return m >> 1;
      5: return (m ^ (m >> 1));
      6: return 64'h5555_5555_5555_5555 & m;
      7: return 64'hAAAA_AAAA_AAAA_AAAA & m;
      8: return 64'd1 << (w - 2);
      9: return (m ^ (m >> 1)) | 64'd1;
      10: return 64'h0F0F_0F0F_0F0F_0F0F & m;
      default: return (m >> 1) ^ 64'd1;
    endcase
  endfunction

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    int cl [30] = '{-128, -70, -65, -64, -63, -33, -32, -31, -17, -16, -15, -9, -8, -7,
                    -1, 0, 1, 7, 8, 9, 15, 16, 17, 31, 32, 33, 63, 64, 65, 127};
    repeat (3) @(posedge clk);
    #1;
    // R13: reset state
    check("R13", result, 64'd0);
    check("R13", {63'd0, sat_sticky}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7/R12: saturate, then a clean op keeps the flag set while result changes
    run_op(64'h40, 64'd2, 2'd0, 2'b00, 1'b0, 1'b1, 1'b0);
    run_op(64'h05, 64'd1, 2'd0, 2'b00, 1'b0, 1'b1, 1'b0);
    // R13: hold with op_valid low while inputs change
    held = result;
    @(negedge clk);
    op_valid = 1'b0; src_opnd = 64'h7F; amt_opnd = 64'd3; sat_en = 1'b1;
    @(posedge clk);
    #1;
    check("R13", result, held);
    check("R13", {63'd0, sat_sticky}, 64'd1);
    do_reset();
    // R8/R12: overflow with saturation off leaves flag clear
    run_op(64'h12, 64'd8, 2'd0, 2'b00, 1'b0, 1'b0, 1'b0);

    // Exhaustive 8-bit sweep with garbage in unused operand bits (R1)
    for (int md = 0; md < 3; md++)
      for (int rs = 0; rs < 4; rs++)
        for (int c = -10; c <= 10; c++)
          for (int v = 0; v < 256; v++)
            run_op({56'hA5C3_96E1_0F7B_D2, 8'(v)}, {56'hF00D_BEEF_1234_56, 8'(c)},
                   2'd0, 2'(md), rs[0], rs[1], 1'b1);

    // Wider sizes: boundary patterns against boundary counts
    for (int sz = 1; sz < 4; sz++)
      for (int md = 0; md < 4; md++)
        for (int rs = 0; rs < 4; rs++)
          for (int k = 0; k < 12; k++)
            for (int j = 0; j < 30; j++)
              run_op(pat(k, 8 << sz) | (~(((8 << sz) == 64) ? 64'h0 : ~((64'd1 << (8 << sz)) - 64'd1)) ^ 64'hFFFF_FFFF_FFFF_FFFF) & 64'h3C3C_3C3C_3C3C_3C3C,
                     {56'h00C0_FFEE_0000_01, 8'(cl[j])}, 2'(sz), 2'(md), rs[0], rs[1], 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule